// File: doc/BRIEF.md
# Loadable-Table Mealy Machine

This block runs any Mealy finite state machine whose transition and output functions are held in a writable lookup table instead of fixed logic. The current state code and the current input symbol are joined into one address. The word at that address holds two fields: the next-state code and the output code. The output field drives the block's output combinationally, with no register on the way. The next-state field is captured into the state register on a clock edge, and only on cycles where the step strobe is high.

A host fills the table through a synchronous write port while the machine is idle, meaning the step strobe is low. It may do so during reset as well. It then drives symbols with the step strobe. Parameters set the number of states `NUM_STATES`, the symbol width `IN_W` and the output width `OUT_W`. The state code is `ST_W = ceil(log2(NUM_STATES))` bits wide. The table holds `2^(ST_W+IN_W)` words of `ST_W+OUT_W` bits. With the defaults (5 states, 1 input bit, 2 output bits) that is 16 words of 5 bits.

Top module: `mealy_tbl_fsm`

## Requirements
- R1: When `rst_ni` is low, `state_o` is 0 at once, without waiting for a clock edge. It stays 0 until reset is released.
- R2: The table address is `{state_o, sym_i}`, with the state bits in the upper positions. Each word is `{next_state[ST_W-1:0], out[OUT_W-1:0]}`, with the next state in the upper bits. `out_o` equals the out field of the addressed word in the same cycle.
- R3: On a rising edge with `step_i` high, `state_o` takes the next-state field of the word addressed in that cycle, if that code is below `NUM_STATES`.
- R4: On a rising edge with `step_i` low, `state_o` keeps its value, whatever `sym_i` is.
- R5: On a rising edge with `step_i` high, a next-state code of `NUM_STATES` or greater sends `state_o` to 0. A code of `NUM_STATES-1` is still taken as given.
- R6: A write (`wr_en_i` high while `step_i` is low) stores `wr_data_i` at `wr_addr_i` on the rising edge. Reads see the new word from the next cycle onward.
- R7: A write attempted while `step_i` is high is dropped, and the table entry keeps its old content.
- R8: When loaded with a detector for the overlapping pattern 1011, the block flags every occurrence with out code 1. In that table, state 3 with input 1 gives next state 1 and out 1. Every other out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the state register |
| step_i | input | 1 | Advance the machine this cycle; also blocks table writes |
| sym_i | input | IN_W | Current input symbol |
| wr_en_i | input | 1 | Table write request |
| wr_addr_i | input | ST_W+IN_W | Table write address `{state, symbol}` |
| wr_data_i | input | ST_W+OUT_W | Table write word `{next_state, out}` |
| out_o | output | OUT_W | Mealy output for the current state and symbol |
| state_o | output | ST_W | Current state code |

## Verification
The 1011 detector is loaded into the table and driven with several bit streams. An all-ones run checks that the machine stays in state 1 and never flags. Repeated 1011011 checks that overlapping matches share their leading 1. Alternating 10 parks the machine between states 2 and 3. Random streams with random gaps in `step_i` show whether a held cycle wrongly consumes a symbol. The expected outputs come from a pattern matcher that works on the stream history, not on states. Separate directed sequences write illegal next-state codes (7) and the highest legal one (4), attempt a write while stepping, and pulse reset in the middle of a run.

// File: rtl/mealy_tbl_pkg.sv
package mealy_tbl_pkg;
  // width of a code able to hold values 0..n-1, never below one bit
  function automatic int code_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mealy_tbl_mem.sv
module mealy_tbl_mem #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 5
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // asynchronous read: output path has zero latency
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mealy_state_reg.sv
module mealy_state_reg #(
  parameter int NUM_STATES = 5,
  parameter int ST_W       = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic [ST_W-1:0] nxt_i,
  output logic [ST_W-1:0] state_o
);
  localparam int CODE_SPAN = 1 << ST_W;

  logic [ST_W-1:0] nxt_legal;
  logic [ST_W-1:0] state_q;

  generate
    if (CODE_SPAN == NUM_STATES) begin : g_full_span
      assign nxt_legal = nxt_i;
    end else begin : g_clamp
      // unused encodings fall back to state 0
      assign nxt_legal = (32'(nxt_i) < NUM_STATES) ? nxt_i : '0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= '0;
    else if (step_i) state_q <= nxt_legal;
  end

  assign state_o = state_q;
endmodule

// File: rtl/mealy_tbl_fsm.sv
module mealy_tbl_fsm #(
  parameter int NUM_STATES = 5,
  parameter int IN_W       = 1,
  parameter int OUT_W      = 2,
  localparam int ST_W      = mealy_tbl_pkg::code_bits(NUM_STATES),
  localparam int ADDR_W    = ST_W + IN_W,
  localparam int WORD_W    = ST_W + OUT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [IN_W-1:0]   sym_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [OUT_W-1:0]  out_o,
  output logic [ST_W-1:0]   state_o
);
  logic [ST_W-1:0]   state;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_word;
  logic              wr_go;

  // table may only change while the machine is idle
  assign wr_go   = wr_en_i & ~step_i;
  assign rd_addr = {state, sym_i};

  mealy_tbl_mem #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
  ) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_go),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_word)
  );

  mealy_state_reg #(
    .NUM_STATES (NUM_STATES),
    .ST_W       (ST_W)
  ) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step_i),
    .nxt_i   (rd_word[WORD_W-1:OUT_W]),
    .state_o (state)
  );

  assign out_o   = rd_word[OUT_W-1:0];
  assign state_o = state;
endmodule

// File: rtl/mealy_tbl_fsm_chk.sv
module mealy_tbl_fsm_chk #(
  parameter int NUM_STATES = 5,
  parameter int IN_W       = 1,
  parameter int OUT_W      = 2,
  parameter int ST_W       = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  step_i,
  input logic [IN_W-1:0]       sym_i,
  input logic                  wr_en_i,
  input logic [ST_W+IN_W-1:0]  wr_addr_i,
  input logic [ST_W+OUT_W-1:0] wr_data_i,
  input logic [ST_W+OUT_W-1:0] rd_word_i,
  input logic [ST_W-1:0]       state_o
);
  logic [ST_W-1:0] nxt_f;
  assign nxt_f = rd_word_i[ST_W+OUT_W-1:OUT_W];

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(state_o));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && (32'(nxt_f) < NUM_STATES)) |=> (state_o == $past(nxt_f)));

  p_clamp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && (32'(nxt_f) >= NUM_STATES)) |=> (state_o == '0));

  p_state_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(state_o) < NUM_STATES);

  p_write_vis_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !step_i) |=>
      (({state_o, sym_i} != $past(wr_addr_i)) || (rd_word_i == $past(wr_data_i))));
endmodule

bind mealy_tbl_fsm mealy_tbl_fsm_chk #(
  .NUM_STATES (NUM_STATES),
  .IN_W       (IN_W),
  .OUT_W      (OUT_W),
  .ST_W       (ST_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .step_i    (step_i),
  .sym_i     (sym_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .rd_word_i (rd_word),
  .state_o   (state_o)
);

// File: tb/mealy_tbl_fsm_tb_top.sv
module mealy_tbl_fsm_tb_top;
  localparam int NS = 5, IW = 1, OW = 2, SW = 3, AW = 4, WW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          step_i = 1'b0;
  logic [IW-1:0] sym_i = '0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [WW-1:0] wr_data_i = '0;
  logic [OW-1:0] out_o;
  logic [SW-1:0] state_o;

  int total = 0;
  int bad = 0;
  int hist = 0;   // bits stepped since reset, newest in bit 0
  int cnt = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  mealy_tbl_fsm dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .sym_i(sym_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .out_o(out_o), .state_o(state_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // longest suffix of the history that is a prefix of 1011
  function automatic int ref_state();
    if (cnt >= 3 && (hist & 7) == 5) return 3;
    if (cnt >= 2 && (hist & 3) == 2) return 2;
    if (cnt >= 1 && (hist & 1) == 1) return 1;
    return 0;
  endfunction

  function automatic int ref_out(input int b);
    return (cnt >= 3 && (hist & 7) == 5 && b == 1) ? 1 : 0;
  endfunction

  task automatic wr(input int a, input int nxt, input int o);
    @(negedge clk_i);
    step_i = 1'b0; wr_en_i = 1'b1;
    wr_addr_i = AW'(a); wr_data_i = WW'((nxt << OW) | o);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic int det_next(input int s, input int b);
    case (s)
      0: return b ? 1 : 0;
      1: return b ? 1 : 2;
      2: return b ? 3 : 0;
      3: return b ? 1 : 2;
      default: return 0;
    endcase
  endfunction

  task automatic load_detector();
    for (int a = 0; a < 16; a++) begin
      int s = a >> 1;
      int b = a & 1;
      wr(a, (s < 4) ? det_next(s, b) : 0, (s == 3 && b == 1) ? 1 : 0);
    end
  endtask

  // one cycle of the detector run, checked against the reference matcher
  task automatic run_bit(input int b, input bit st);
    @(negedge clk_i);
    sym_i = IW'(b); step_i = st;
    #2;
    chk("R8 out", int'(out_o), ref_out(b));
    chk("R8 state", int'(state_o), ref_state());
    if (st) begin
      hist = (hist << 1) | b;
      cnt++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    step_i = 1'b0; rst_ni = 1'b0;
    #2;
    chk("R1 async reset", int'(state_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    hist = 0; cnt = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset state", int'(state_o), 0);
    load_detector();   // written while in reset
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R4: hold with step low
    run_bit(1, 1'b1);
    for (int i = 0; i < 6; i++) run_bit(i & 1, 1'b0);
    chk("R4 hold", int'(state_o), 1);

    do_reset();
    for (int i = 0; i < 12; i++) run_bit(1, 1'b1);          // all ones
    do_reset();
    for (int i = 0; i < 28; i++) run_bit((7'b1011011 >> (6 - (i % 7))) & 1, 1'b1);  // overlap
    do_reset();
    for (int i = 0; i < 20; i++) run_bit((i & 1) ? 0 : 1, 1'b1);  // 1010..
    do_reset();
    for (int i = 0; i < 3000; i++) run_bit($urandom_range(1), ($urandom_range(3) != 0));

    // R1: reset mid-run from a nonzero state
    run_bit(1, 1'b1);
    do_reset();

    // R7: write while stepping is dropped
    @(negedge clk_i);
    sym_i = 1'b0; step_i = 1'b1; wr_en_i = 1'b1;
    wr_addr_i = AW'(1); wr_data_i = WW'((2 << OW) | 3);
    @(negedge clk_i);
    wr_en_i = 1'b0; step_i = 1'b0; sym_i = 1'b1;
    #2;
    chk("R7 write dropped out", int'(out_o), 0);

    // R6: write while idle lands, visible next cycle
    wr(1, 3, 2);
    sym_i = 1'b1;
    #2;
    chk("R6 new word out", int'(out_o), 2);
    step_i = 1'b1;
    @(negedge clk_i);
    step_i = 1'b0;
    #2;
    chk("R6 new word next", int'(state_o), 3);
    chk("R8 state3 in1 out", (sym_i == 1'b1) ? int'(out_o) : -1, 1);
    step_i = 1'b1;
    @(negedge clk_i);
    step_i = 1'b0;
    #2;
    chk("R8 state3 in1 next", int'(state_o), 1);
    wr(1, 1, 0);

    // R5: illegal next code 7 from state 1, legal 4 from state 1
    do_reset();
    wr(2, 7, 3);
    wr(3, 4, 2);
    sym_i = 1'b1; step_i = 1'b1;
    @(negedge clk_i);
    sym_i = 1'b0; step_i = 1'b0;
    #2;
    chk("R3 step to 1", int'(state_o), 1);
    chk("R2 out field", int'(out_o), 3);
    step_i = 1'b1;
    @(negedge clk_i);
    step_i = 1'b0;
    #2;
    chk("R5 clamp to 0", int'(state_o), 0);
    sym_i = 1'b1; step_i = 1'b1;
    @(negedge clk_i);
    #2;
    chk("R2 out field s1", int'(out_o), 2);
    @(negedge clk_i);
    step_i = 1'b0;
    #2;
    chk("R5 top legal code", int'(state_o), 4);
    @(negedge clk_i);
    #2;
    chk("R4 hold in 4", int'(state_o), 4);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule